// File: doc/BRIEF.md
# Instruction Working-Set Phase Detector

This block watches the stream of retired instruction fetch addresses and decides, once per window of retired instructions, whether the program has moved into a new phase. Addresses are reduced to 64-byte segments and hashed into a 1024-bit signature. Only one retired instruction in eight is sampled into it. Each window has a fixed, programmable instruction count. When a window ends, its signature becomes the reference for the next window and is compared with the reference of the window before it.

The comparison is a relative distance: the number of signature bits set in exactly one of the two signatures, divided by the number set in either. No divider is built. Both sides are scaled and the products are compared. The popcounts are gathered one 64-bit slice per cycle. The result is a phase-change flag, a stable flag and a working-set size estimate, announced by a one-cycle done pulse. Control logic for reconfiguring other units can act on that pulse.

Top module: `wset_phase_detector`

## Requirements
- R1: While reset is asserted and until the first done pulse, window_done, phase_change and window_stable are 0 and ws_size is 0.
- R2: Address bits [5:0] do not affect the signature. The signature index is the XOR of consecutive 10-bit fields of addr[31:6], starting at bit 6, with the top field zero-padded.
- R3: Counting retired instructions from reset as 0, 1, 2, ..., only instructions whose count is a multiple of 8 set a signature bit. The others leave the signature unchanged.
- R4: A window closes after cfg_window_len retired instructions. Cycles without retire_valid do not count. The 24-bit length accepts 100,000 and 1,000,000.
- R5: An instruction that retires in the cycle in which a window closes belongs to the new window, both in the count and in the signature.
- R6: With x = popcount(new XOR previous), o = popcount(new OR previous) and a 4-bit threshold thr in sixteenths (8 is 50%), phase_change is 1 when 16*x > thr*o. The threshold is captured when the window closes.
- R7: window_stable is 1 when 16*x < thr*o. When the two sides are equal, neither flag is set.
- R8: The first window after reset always reports phase_change=1 and window_stable=0.
- R9: ws_size is the number of set bits in the signature of the window just closed, at most 1024.
- R10: window_done is a single-cycle pulse. It is first seen 17 clock edges after the edge that registers the window's last retired instruction. The flags and ws_size hold their values until the next pulse.
- R11: phase_change and window_stable are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_valid | input | 1 | One instruction retires this cycle |
| retire_addr | input | 32 | Fetch address of the retiring instruction |
| cfg_window_len | input | 24 | Window length in retired instructions, at least 1 |
| cfg_threshold | input | 4 | Distance threshold in sixteenths |
| window_done | output | 1 | One-cycle pulse: new results are valid |
| phase_change | output | 1 | Distance above threshold, or first window |
| window_stable | output | 1 | Distance below threshold |
| ws_size | output | 11 | Set-bit count of the closed window's signature |

## Verification
The block has a fixed schedule. The window closes on the edge after the last counted retire, and 16 more edges scan the slices. The result therefore lands 17 edges after the last retire. The bench counts edges from the cycle it drops retire_valid and requires the pulse exactly at that count before it compares flags and size. The flags and size are sampled on the falling edge of the pulse cycle. In the one test where retires continue across a window end, the bench also counts the pulses it sees during the feed, so the earlier window's pulse cannot be taken for the later one.

// File: rtl/wset_pkg.sv
package wset_pkg;
    // segment granularity: 64-byte blocks
    localparam int SEG_LSB       = 6;
    localparam int DEF_ADDR_W    = 32;
    localparam int DEF_SIG_BITS  = 1024;
    localparam int DEF_WIN_W     = 24;
    localparam int DEF_SAMPLE_LG = 3;
    localparam int DEF_THR_W     = 4;
    localparam int DEF_CHUNK     = 64;
endpackage

// File: rtl/wset_sampler.sv
module wset_sampler
    import wset_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int IDX_W     = 10,
    parameter int WIN_W     = DEF_WIN_W,
    parameter int SAMPLE_LG = DEF_SAMPLE_LG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_valid,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [WIN_W-1:0]  win_len,
    output logic              samp_valid,
    output logic [IDX_W-1:0]  samp_idx,
    output logic              boundary
);
    localparam int SEG_W  = ADDR_W - SEG_LSB;
    localparam int NFOLD  = (SEG_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = NFOLD * IDX_W;
    localparam int SCNT_W = (SAMPLE_LG > 0) ? SAMPLE_LG : 1;
    localparam logic [SCNT_W-1:0] SMASK = SCNT_W'((1 << SAMPLE_LG) - 1);

    typedef struct packed {
        logic [WIN_W-1:0]  win_cnt;
        logic [SCNT_W-1:0] smp_cnt;
    } samp_st_t;

    samp_st_t st_d, st_q;
    logic [PAD_W-1:0] seg_pad;
    logic [IDX_W-1:0] fold;

    always_comb begin
        seg_pad = PAD_W'(ret_addr[ADDR_W-1:SEG_LSB]);
        fold    = '0;
        for (int k = 0; k < NFOLD; k++) begin
            fold = fold ^ seg_pad[k*IDX_W +: IDX_W];
        end
    end

    always_comb begin
        st_d       = st_q;
        boundary   = (st_q.win_cnt >= win_len);
        samp_valid = ret_valid && ((st_q.smp_cnt & SMASK) == '0);
        samp_idx   = fold;
        if (ret_valid) begin
            st_d.smp_cnt = st_q.smp_cnt + SCNT_W'(1);
        end
        if (boundary) begin
            st_d.win_cnt = ret_valid ? WIN_W'(1) : '0;
        end else if (ret_valid) begin
            st_d.win_cnt = st_q.win_cnt + WIN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wset_sig_store.sv
module wset_sig_store #(
    parameter int SIG_BITS = 1024,
    parameter int IDX_W    = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                samp_valid,
    input  logic [IDX_W-1:0]    samp_idx,
    input  logic                boundary,
    output logic [SIG_BITS-1:0] ref_sig,
    output logic [SIG_BITS-1:0] diff_sig
);
    typedef struct packed {
        logic [SIG_BITS-1:0] cur;
        logic [SIG_BITS-1:0] prv;
        logic [SIG_BITS-1:0] dif;
    } sig_st_t;

    sig_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (boundary) begin
            st_d.prv = st_q.cur;
            st_d.dif = st_q.cur ^ st_q.prv;
            st_d.cur = '0;
        end
        if (samp_valid) begin
            st_d.cur[samp_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ref_sig  = st_q.prv;
    assign diff_sig = st_q.dif;
endmodule

// File: rtl/wset_scan.sv
module wset_scan #(
    parameter int SIG_BITS = 1024,
    parameter int CHUNK    = 64,
    parameter int THR_W    = 4,
    parameter int CNT_W    = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [THR_W-1:0]    thr,
    input  logic [SIG_BITS-1:0] ref_sig,
    input  logic [SIG_BITS-1:0] diff_sig,
    output logic                done,
    output logic                change,
    output logic                stable,
    output logic [CNT_W-1:0]    size
);
    localparam int NCHUNK = SIG_BITS / CHUNK;
    localparam int NCH_W  = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;
    localparam int PROD_W = CNT_W + THR_W;
    localparam int PC_W   = $clog2(CHUNK + 1);

    typedef struct packed {
        logic             busy;
        logic [NCH_W-1:0] idx;
        logic [CNT_W-1:0] acc_x;
        logic [CNT_W-1:0] acc_o;
        logic [CNT_W-1:0] acc_s;
        logic [THR_W-1:0] thr;
        logic             first_pend;
        logic             first_cap;
        logic             done;
        logic             change;
        logic             stable;
        logic [CNT_W-1:0] size;
    } scan_st_t;

    scan_st_t st_d, st_q;
    logic [CHUNK-1:0]  sl_x, sl_o, sl_s;
    logic [PC_W-1:0]   pc_x, pc_o, pc_s;
    logic [CNT_W-1:0]  tx, to, ts;
    logic [PROD_W-1:0] lhs, rhs;

    always_comb begin
        sl_x = diff_sig[int'(st_q.idx)*CHUNK +: CHUNK];
        sl_s = ref_sig[int'(st_q.idx)*CHUNK +: CHUNK];
        sl_o = sl_x | sl_s;
        pc_x = '0;
        pc_o = '0;
        pc_s = '0;
        for (int b = 0; b < CHUNK; b++) begin
            pc_x = pc_x + PC_W'(sl_x[b]);
            pc_o = pc_o + PC_W'(sl_o[b]);
            pc_s = pc_s + PC_W'(sl_s[b]);
        end
        tx  = st_q.acc_x + CNT_W'(pc_x);
        to  = st_q.acc_o + CNT_W'(pc_o);
        ts  = st_q.acc_s + CNT_W'(pc_s);
        lhs = PROD_W'(tx) << THR_W;
        rhs = PROD_W'(st_q.thr) * PROD_W'(to);
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            st_d.acc_x = tx;
            st_d.acc_o = to;
            st_d.acc_s = ts;
            st_d.idx   = st_q.idx + NCH_W'(1);
            if (st_q.idx == NCH_W'(NCHUNK - 1)) begin
                st_d.busy   = 1'b0;
                st_d.done   = 1'b1;
                st_d.change = st_q.first_cap || (lhs > rhs);
                st_d.stable = !st_q.first_cap && (lhs < rhs);
                st_d.size   = ts;
            end
        end
        if (start) begin
            st_d.busy       = 1'b1;
            st_d.idx        = '0;
            st_d.acc_x      = '0;
            st_d.acc_o      = '0;
            st_d.acc_s      = '0;
            st_d.thr        = thr;
            st_d.first_cap  = st_q.first_pend;
            st_d.first_pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.first_pend <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign done   = st_q.done;
    assign change = st_q.change;
    assign stable = st_q.stable;
    assign size   = st_q.size;
endmodule

// File: rtl/wset_phase_detector.sv
module wset_phase_detector
    import wset_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int SIG_BITS  = DEF_SIG_BITS,
    parameter int WIN_W     = DEF_WIN_W,
    parameter int SAMPLE_LG = DEF_SAMPLE_LG,
    parameter int THR_W     = DEF_THR_W,
    parameter int CHUNK     = DEF_CHUNK,
    localparam int IDX_W    = $clog2(SIG_BITS),
    localparam int CNT_W    = $clog2(SIG_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retire_valid,
    input  logic [ADDR_W-1:0] retire_addr,
    input  logic [WIN_W-1:0]  cfg_window_len,
    input  logic [THR_W-1:0]  cfg_threshold,
    output logic              window_done,
    output logic              phase_change,
    output logic              window_stable,
    output logic [CNT_W-1:0]  ws_size
);
    logic                samp_valid;
    logic [IDX_W-1:0]    samp_idx;
    logic                boundary;
    logic [SIG_BITS-1:0] ref_sig;
    logic [SIG_BITS-1:0] diff_sig;

    wset_sampler #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WIN_W(WIN_W), .SAMPLE_LG(SAMPLE_LG)
    ) u_sampler (
        .clk(clk), .rst_n(rst_n),
        .ret_valid(retire_valid), .ret_addr(retire_addr), .win_len(cfg_window_len),
        .samp_valid(samp_valid), .samp_idx(samp_idx), .boundary(boundary)
    );

    wset_sig_store #(
        .SIG_BITS(SIG_BITS), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .samp_valid(samp_valid), .samp_idx(samp_idx), .boundary(boundary),
        .ref_sig(ref_sig), .diff_sig(diff_sig)
    );

    wset_scan #(
        .SIG_BITS(SIG_BITS), .CHUNK(CHUNK), .THR_W(THR_W), .CNT_W(CNT_W)
    ) u_scan (
        .clk(clk), .rst_n(rst_n),
        .start(boundary), .thr(cfg_threshold),
        .ref_sig(ref_sig), .diff_sig(diff_sig),
        .done(window_done), .change(phase_change), .stable(window_stable), .size(ws_size)
    );
endmodule

// File: rtl/wset_phase_checker.sv
module wset_phase_checker #(
    parameter int SIG_BITS = 1024,
    parameter int CNT_W    = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             window_done,
    input logic             phase_change,
    input logic             window_stable,
    input logic [CNT_W-1:0] ws_size
);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        window_done |=> !window_done);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !window_done |-> $stable({phase_change, window_stable, ws_size}));

    // R11
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(phase_change && window_stable));

    // R9
    size_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ws_size <= CNT_W'(SIG_BITS));
endmodule

bind wset_phase_detector wset_phase_checker #(
    .SIG_BITS(SIG_BITS), .CNT_W(CNT_W)
) u_phase_chk (
    .clk(clk), .rst_n(rst_n),
    .window_done(window_done), .phase_change(phase_change),
    .window_stable(window_stable), .ws_size(ws_size)
);

// File: tb/wset_phase_detector_bench.sv
`timescale 1ns/1ps
module wset_phase_detector_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire_valid = 1'b0;
    logic [31:0] retire_addr = '0;
    logic [23:0] cfg_window_len = 24'd16;
    logic [3:0]  cfg_threshold = 4'd8;
    logic        window_done;
    logic        phase_change;
    logic        window_stable;
    logic [10:0] ws_size;

    int checks = 0;
    int errors = 0;
    int seen_done = 0;
    logic seen_chg = 1'b0;

    always #2 clk = ~clk;

    wset_phase_detector u_wset_phase_detector (
        .clk(clk), .rst_n(rst_n),
        .retire_valid(retire_valid), .retire_addr(retire_addr),
        .cfg_window_len(cfg_window_len), .cfg_threshold(cfg_threshold),
        .window_done(window_done), .phase_change(phase_change),
        .window_stable(window_stable), .ws_size(ws_size)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [3:0]  thr;
        logic        chg;
        logic        stb;
        logic [10:0] sz;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{a: 32'(1<<6), b: 32'(2<<6), thr: 4'd8,  chg: 1'b1, stb: 1'b0, sz: 11'd2},  // R8 first window
        '{a: 32'(1<<6), b: 32'(2<<6), thr: 4'd8,  chg: 1'b0, stb: 1'b1, sz: 11'd2},
        '{a: 32'(1<<6), b: 32'(3<<6), thr: 4'd8,  chg: 1'b1, stb: 1'b0, sz: 11'd2},
        '{a: 32'(3<<6), b: 32'(3<<6), thr: 4'd8,  chg: 1'b0, stb: 1'b0, sz: 11'd1},  // R7 equal
        '{a: 32'(3<<6), b: 32'(4<<6), thr: 4'd4,  chg: 1'b1, stb: 1'b0, sz: 11'd2},
        '{a: 32'(5<<6), b: 32'(6<<6), thr: 4'd15, chg: 1'b1, stb: 1'b0, sz: 11'd2},
        '{a: 32'(5<<6), b: 32'(6<<6), thr: 4'd0,  chg: 1'b0, stb: 1'b0, sz: 11'd2},
        '{a: 32'(6<<6), b: 32'(7<<6), thr: 4'd0,  chg: 1'b1, stb: 1'b0, sz: 11'd2},
        '{a: 32'(6<<6), b: 32'(6<<6), thr: 4'd8,  chg: 1'b0, stb: 1'b0, sz: 11'd1},
        '{a: 32'((6<<6)|32'h3f), b: 32'((5<<16)|(3<<6)), thr: 4'd8, chg: 1'b0, stb: 1'b1, sz: 11'd1} // R2 fold
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // one retired instruction per call; samples done before driving
    task automatic retire(input logic [31:0] addr);
        @(negedge clk);
        if (window_done) begin
            seen_done++;
            seen_chg = phase_change;
        end
        retire_valid = 1'b1;
        retire_addr  = addr;
    endtask

    task automatic idle_one();
        @(negedge clk);
        if (window_done) begin
            seen_done++;
            seen_chg = phase_change;
        end
        retire_valid = 1'b0;
    endtask

    // R3: filler instructions use segments never sampled
    task automatic feed16(input logic [31:0] a, input logic [31:0] b);
        for (int p = 0; p < 16; p++) begin
            if (p == 0)      retire(a);
            else if (p == 8) retire(b);
            else             retire(32'((900 + p) << 6));
        end
    endtask

    // counts edges from the idle cycle until done; R10 latency
    task automatic wait_done(output int lat);
        lat = 0;
        for (int n = 1; n <= 200; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (window_done) begin
                lat = n;
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 done", int'(window_done), 0);
        chk("R1 change", int'(phase_change), 0);
        chk("R1 stable", int'(window_stable), 0);
        chk("R1 size", int'(ws_size), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle after reset", int'(window_done), 0);

        // table walk: R6 R7 R8 R9 R10 R2 R3
        for (int r = 0; r < 10; r++) begin
            cfg_threshold = VEC[r].thr;
            feed16(VEC[r].a, VEC[r].b);
            idle_one();
            wait_done(lat);
            chk($sformatf("R10 latency row %0d", r), lat, 17);
            chk($sformatf("R6 change row %0d", r), int'(phase_change), int'(VEC[r].chg));
            chk($sformatf("R7 stable row %0d", r), int'(window_stable), int'(VEC[r].stb));
            chk($sformatf("R9 size row %0d", r), int'(ws_size), int'(VEC[r].sz));
            repeat (5) @(negedge clk);
            chk($sformatf("R10 hold row %0d", r), int'(phase_change), int'(VEC[r].chg));
        end

        // R5: retire on the closing cycle goes to the new window; R4 idle gap
        cfg_threshold = 4'd8;
        seen_done = 0;
        feed16(32'(10 << 6), 32'(10 << 6));
        retire(32'(10 << 6));                 // closing cycle of previous window
        for (int p = 1; p < 16; p++) begin
            if (p == 4) idle_one();
            if (p == 8) retire(32'(11 << 6));
            else        retire(32'((900 + p) << 6));
        end
        idle_one();
        chk("R4 one pulse during feed", seen_done, 1);
        chk("R6 change of window A", int'(seen_chg), 1);
        wait_done(lat);
        chk("R5 latency", lat, 17);
        chk("R5 change", int'(phase_change), 0);
        chk("R5 stable", int'(window_stable), 0);
        chk("R5 size", int'(ws_size), 2);

        // R4: longer window, only counted retires close it
        cfg_window_len = 24'd40;
        seen_done = 0;
        for (int p = 0; p < 40; p++) begin
            if (p == 20) begin idle_one(); idle_one(); end
            retire(32'(20 << 6));
        end
        idle_one();
        chk("R4 no early pulse", seen_done, 0);
        wait_done(lat);
        chk("R4 latency len 40", lat, 17);
        chk("R4 change len 40", int'(phase_change), 1);
        chk("R9 size len 40", int'(ws_size), 1);

        // R8: reset again, first window reports change even if identical
        rst_n = 1'b0;
        cfg_window_len = 24'd16;
        repeat (2) @(negedge clk);
        chk("R1 size after reset", int'(ws_size), 0);
        rst_n = 1'b1;
        feed16(32'(20 << 6), 32'(20 << 6));
        idle_one();
        wait_done(lat);
        chk("R8 first change", int'(phase_change), 1);
        chk("R8 first stable", int'(window_stable), 0);
        finish_run();
    end
endmodule